// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

This block holds two up counters, a low one and a high one. Each has a compare value and a run bit. In split mode each counter is an interval timer of its own. On each tick from its chosen source a counter advances, and when it reaches its compare value it clears and gives a one-cycle match pulse. In cascade mode the two counters form one counter of twice the width. The high counter then advances each time the low counter wraps, and the match pulse comes from comparing the joined count with the joined compare value.

The tick sources are single-cycle enables from a shared prescaler (divide by 2, 8, 32 and 512 taps) and one external count input. The external input is synchronized, and each of its rising edges counts once. In split mode the high counter can also be clocked by the match events of the low counter. This gives a chained divider without cascade mode.

Top module: `dual_interval_timer`

## Requirements
- R1: While reset is applied, and after it, both counters are zero and stopped, and `match_lo` and `match_hi` are low. With both run bits low, no match pulse appears whatever the tick inputs do.
- R2: While a counter's run bit is low, that counter is held at zero and ignores ticks. When the bit is set again, counting starts from zero.
- R3: `sel_lo` picks the low counter's tick: 2'b00 is an external rising edge, 2'b01 is `tick_p1`, 2'b10 is `tick_p2` and 2'b11 is `tick_p3`.
- R4: In split mode (`cascade` = 0), `sel_hi` picks the high counter's tick: 2'b00 is a low-counter match event, 2'b01 is `tick_p1`, 2'b10 is `tick_p3` and 2'b11 is `tick_p4`.
- R5: `ext_in` passes through a synchronizer of two flip-flops. Each rising edge gives exactly one tick, and a level held high gives only one.
- R6: In split mode, a tick that finds a counter equal to its compare value clears the counter to zero. That counter's match output is then high for the single cycle after the tick's clock edge, so pulses come every compare+1 ticks.
- R7: A compare value of zero gives a match pulse on every tick.
- R8: In cascade mode (`cascade` = 1), the high counter advances once each time the low counter wraps from all ones to zero, and `sel_hi` has no effect.
- R9: In cascade mode, a low-counter tick that finds {high, low} equal to {`cmp_hi`, `cmp_lo`} clears both counters and pulses `match_hi` for one cycle. `match_lo` stays low in cascade mode.
- R10: Each counter has its own run bit. With `run_hi` low the high counter stays stopped and `match_hi` stays low while the low counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_p1 | input | 1 | Prescaler tick, finest tap |
| tick_p2 | input | 1 | Prescaler tick, second tap |
| tick_p3 | input | 1 | Prescaler tick, third tap |
| tick_p4 | input | 1 | Prescaler tick, coarsest tap |
| ext_in | input | 1 | External count input, asynchronous |
| cascade | input | 1 | 1 joins the counters into one double-width counter |
| sel_lo | input | 2 | Low counter tick source |
| sel_hi | input | 2 | High counter tick source (split mode) |
| run_lo | input | 1 | Low counter run bit |
| run_hi | input | 1 | High counter run bit |
| cmp_lo | input | CNT_W | Low counter compare value |
| cmp_hi | input | CNT_W | High counter compare value |
| match_lo | output | 1 | Low counter match pulse |
| match_hi | output | 1 | High counter or joined match pulse |

## Verification
The bench builds the block with its defaults, CNT_W = 8 and SYNC_STAGES = 2. At that width a low-counter wrap takes 256 ticks and a joined period of 300 ticks takes a few hundred cycles, so the carry into the high counter and the joined compare are both reached quickly. With a compare value of 255 the low counter reaches all ones and gets there by a match, not a wrap. The two-stage synchronizer sets the delay from an external edge to its tick, and the bench lets that delay run out before it closes each count window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Two-bit tick source code shared by both counters
  typedef enum logic [1:0] {
    SRC_ALT  = 2'b00,  // external edge (low) / low match event (high)
    SRC_TAPA = 2'b01,
    SRC_TAPB = 2'b10,
    SRC_TAPC = 2'b11
  } src_sel_e;
endpackage

// File: rtl/tmr_reset_sync.sv
module tmr_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) meta_q <= 2'b00;
    else        meta_q <= {meta_q[0], 1'b1};
  end

  assign srst_n = meta_q[1];
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic srst_n,
  input  logic din,
  output logic rise
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] shift_q;
  logic [DEPTH-1:0] shift_d;

  always_comb shift_d = {shift_q[DEPTH-2:0], din};

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  // one tick per low-to-high transition after synchronization
  assign rise = shift_q[DEPTH-2] & ~shift_q[DEPTH-1];

  // R5: a rise cannot be followed by another rise in the next cycle
  p_single_tick_r5: assert property (@(posedge clk) disable iff (!srst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr_count_stage.sv
module tmr_count_stage #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = !run || clr || tick;
    if (!run || clr) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2: a stopped counter reads zero on the next cycle
  p_stop_zero_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !run |=> cnt_q == '0);

  // R2: with no tick and no clear, the count holds
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!srst_n)
    run && !tick && !clr |=> $stable(cnt_q));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_p1,
  input  logic             tick_p2,
  input  logic             tick_p3,
  input  logic             tick_p4,
  input  logic             ext_in,
  input  logic             cascade,
  input  logic [1:0]       sel_lo,
  input  logic [1:0]       sel_hi,
  input  logic             run_lo,
  input  logic             run_hi,
  input  logic [CNT_W-1:0] cmp_lo,
  input  logic [CNT_W-1:0] cmp_hi,
  output logic             match_lo,
  output logic             match_hi
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic             srst_n;
  logic             ext_rise;
  logic [CNT_W-1:0] cnt_lo, cnt_hi;
  logic             tick_lo, tick_hi_sel, tick_hi;
  logic             hit_lo, hit_hi, full_hit, wrap_lo;
  logic             clr_lo, clr_hi;
  logic             mlo_d, mhi_d, mlo_q, mhi_q;
  src_sel_e         src_lo, src_hi;

  tmr_reset_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk    (clk),
    .srst_n (srst_n),
    .din    (ext_in),
    .rise   (ext_rise)
  );

  assign src_lo = src_sel_e'(sel_lo);
  assign src_hi = src_sel_e'(sel_hi);

  // low counter source: external edge or one of three finer taps
  always_comb begin
    unique case (src_lo)
      SRC_ALT:  tick_lo = ext_rise;
      SRC_TAPA: tick_lo = tick_p1;
      SRC_TAPB: tick_lo = tick_p2;
      default:  tick_lo = tick_p3;
    endcase
  end

  always_comb hit_lo = run_lo && tick_lo && (cnt_lo == cmp_lo);

  // high counter source in split mode: low match or one of three taps
  always_comb begin
    unique case (src_hi)
      SRC_ALT:  tick_hi_sel = hit_lo;
      SRC_TAPA: tick_hi_sel = tick_p1;
      SRC_TAPB: tick_hi_sel = tick_p3;
      default:  tick_hi_sel = tick_p4;
    endcase
  end

  always_comb begin
    full_hit = cascade && run_lo && run_hi && tick_lo &&
               ({cnt_hi, cnt_lo} == {cmp_hi, cmp_lo});
    wrap_lo  = cascade && run_lo && tick_lo && (cnt_lo == ALL_ONES) && !full_hit;
    tick_hi  = cascade ? wrap_lo : tick_hi_sel;
    hit_hi   = !cascade && run_hi && tick_hi_sel && (cnt_hi == cmp_hi);
    clr_lo   = cascade ? full_hit : hit_lo;
    clr_hi   = cascade ? full_hit : hit_hi;
    mlo_d    = !cascade && hit_lo;
    mhi_d    = cascade ? full_hit : hit_hi;
  end

  tmr_count_stage #(.CNT_W(CNT_W)) u_lo (
    .clk    (clk),
    .srst_n (srst_n),
    .run    (run_lo),
    .tick   (tick_lo),
    .clr    (clr_lo),
    .cnt    (cnt_lo)
  );

  tmr_count_stage #(.CNT_W(CNT_W)) u_hi (
    .clk    (clk),
    .srst_n (srst_n),
    .run    (run_hi),
    .tick   (tick_hi),
    .clr    (clr_hi),
    .cnt    (cnt_hi)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mlo_q <= 1'b0;
      mhi_q <= 1'b0;
    end else begin
      mlo_q <= mlo_d;
      mhi_q <= mhi_d;
    end
  end

  assign match_lo = mlo_q;
  assign match_hi = mhi_q;

  // R7: zero compare from a cleared count pulses on the tick
  p_zero_cmp_r7: assert property (@(posedge clk) disable iff (!srst_n)
    !cascade && run_lo && tick_lo && cmp_lo == '0 && cnt_lo == '0 |=> match_lo);

  // R9: low match output stays quiet in cascade mode
  p_quiet_lo_r9: assert property (@(posedge clk) disable iff (!srst_n)
    cascade && $past(cascade) |-> !match_lo);

  // R10: stopped counters give no match pulses
  p_stop_quiet_hi_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !run_hi |=> !match_hi);
  p_stop_quiet_lo_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !run_lo |=> !match_lo);

  // R8: a low wrap in cascade mode advances the high count
  p_carry_r8: assert property (@(posedge clk) disable iff (!srst_n)
    wrap_lo && run_hi && cnt_hi != ALL_ONES |=> cnt_hi != '0 && cnt_lo == '0);
endmodule

// File: tb/sim_dual_interval_timer.sv
`timescale 1ns/1ps
module sim_dual_interval_timer;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cascade, run_lo, run_hi, gate, ext_force;
  logic [1:0] sel_lo, sel_hi;
  logic [W-1:0] cmp_lo, cmp_hi;
  logic match_lo, match_hi;
  logic t1, t2, t3, t4, ext;
  logic [11:0] phs = '0;

  always @(posedge clk) phs <= phs + 1'b1;

  assign t1  = gate;
  assign t2  = gate && (phs[1:0] == 2'b11);
  assign t3  = gate && (phs[3:0] == 4'hF);
  assign t4  = gate && (phs[7:0] == 8'hFF);
  assign ext = ext_force || (gate && phs[1:0] == 2'b10);

  dual_interval_timer #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_p1(t1), .tick_p2(t2), .tick_p3(t3),
    .tick_p4(t4), .ext_in(ext), .cascade(cascade), .sel_lo(sel_lo),
    .sel_hi(sel_hi), .run_lo(run_lo), .run_hi(run_hi), .cmp_lo(cmp_lo),
    .cmp_hi(cmp_hi), .match_lo(match_lo), .match_hi(match_hi)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  typedef struct packed {
    int unsigned win;
    logic        casc;
    logic        rhi;
    logic [1:0]  s0;
    logic [1:0]  s1;
    logic [7:0]  c0;
    logic [7:0]  c1;
    int unsigned e0;
    int unsigned e1;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{64,   1'b0, 1'b1, 2'b01, 2'b01, 8'd3,   8'd9, 16, 6},  // R3 R4 R6
    '{256,  1'b0, 1'b1, 2'b10, 2'b10, 8'd0,   8'd4, 64, 3},  // R3 R4 R7
    '{256,  1'b0, 1'b1, 2'b11, 2'b00, 8'd1,   8'd1, 8,  4},  // R3 R4 chain
    '{512,  1'b0, 1'b1, 2'b01, 2'b11, 8'd255, 8'd0, 2,  2},  // R4 R6 R7
    '{128,  1'b0, 1'b1, 2'b00, 2'b00, 8'd7,   8'd3, 4,  1},  // R3 R5
    '{600,  1'b1, 1'b1, 2'b01, 2'b01, 8'd43,  8'd1, 0,  2},  // R8 R9
    '{16,   1'b1, 1'b1, 2'b01, 2'b10, 8'd0,   8'd0, 0, 16},  // R9
    '{1024, 1'b1, 1'b1, 2'b10, 2'b11, 8'd255, 8'd0, 0,  1},  // R8 R9
    '{64,   1'b0, 1'b0, 2'b01, 2'b01, 8'd3,   8'd0, 16, 0}   // R10
  };

  task automatic idle_cfg();
    run_lo = 1'b0; run_hi = 1'b0; gate = 1'b0; ext_force = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, output int n0, output int n1);
    n0 = 0; n1 = 0;
    @(negedge clk);
    idle_cfg();
    cascade = v.casc; sel_lo = v.s0; sel_hi = v.s1;
    cmp_lo = v.c0; cmp_hi = v.c1;
    repeat (2) @(negedge clk);
    run_lo = 1'b1; run_hi = v.rhi; gate = 1'b1;
    for (int i = 0; i < int'(v.win); i++) begin
      @(negedge clk);
      n0 += int'(match_lo); n1 += int'(match_hi);
    end
    gate = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      n0 += int'(match_lo); n1 += int'(match_hi);
    end
    run_lo = 1'b0; run_hi = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      n0 += int'(match_lo); n1 += int'(match_hi);
    end
  endtask

  initial begin
    int n0, n1, first;
    rst_n = 1'b0; cascade = 1'b0; sel_lo = 2'b01; sel_hi = 2'b01;
    cmp_lo = '0; cmp_hi = '0;
    idle_cfg();
    repeat (3) @(negedge clk);
    chk("R1 match_lo in reset", int'(match_lo), 0);
    chk("R1 match_hi in reset", int'(match_hi), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R2: stopped after reset, ticks ignored even with zero compare
    gate = 1'b1; n0 = 0; n1 = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      n0 += int'(match_lo) + int'(match_hi);
    end
    gate = 1'b0;
    chk("R1 R2 no pulses while stopped", n0, 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      run_vec(VECS[k], n0, n1);
      chk($sformatf("vector %0d match_lo count (R3 R6 R9)", k), n0, int'(VECS[k].e0));
      chk($sformatf("vector %0d match_hi count (R4 R8 R10)", k), n1, int'(VECS[k].e1));
    end

    // R2/R6: restart from zero, pulse exactly on the tenth tick, one cycle wide
    @(negedge clk);
    idle_cfg(); cascade = 1'b0; sel_lo = 2'b01; cmp_lo = 8'd9;
    repeat (2) @(negedge clk);
    run_lo = 1'b1; gate = 1'b1;
    repeat (5) @(negedge clk);
    run_lo = 1'b0;
    @(negedge clk);
    run_lo = 1'b1;
    first = 0; n0 = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (match_lo) begin
        n0++;
        if (first == 0) first = k;
      end
    end
    chk("R2 first pulse tick after restart", first, 10);
    chk("R6 pulse width/count in 12 ticks", n0, 1);

    // R5: held external level counts once
    @(negedge clk);
    idle_cfg(); sel_lo = 2'b00; cmp_lo = 8'd0;
    repeat (2) @(negedge clk);
    run_lo = 1'b1; ext_force = 1'b1; n0 = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      n0 += int'(match_lo);
    end
    ext_force = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      n0 += int'(match_lo);
    end
    chk("R5 held ext level pulses", n0, 1);
    idle_cfg();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule